// File: doc/BRIEF.md
# Camera Receiver Interrupt and Lane Status Registers

This block is the software-visible register set of a multi-lane serial camera receiver. A plain register port carries an address, a write strobe and write data, and returns read data combinationally for the address presented. Single-cycle error pulses from the packet and protocol logic set sticky flags. Two pixel FIFO conditions, full and empty, are mirrored live into the low bits of the same status word. Software clears a sticky flag by writing a one to its bit.

An enable word selects which status bits drive the single interrupt line. The line is registered and is the OR of every status bit whose enable is set. The block also makes visible the raw PHY status of eight data lanes and of one clock lane as read-only words. Reserved positions in those words are masked to zero.

Top module: `rx_irq_csr`

## Requirements
- R1: Byte offsets are decoded as follows: 0x00 is status, 0x04 is enable, 0x08 + 4*n is the status of data lane n for n = 0..7, and 0x28 is the clock lane status. Read data bits above a register's width read as zero.
- R2: Status bit 0 shows fifo_full and status bit 1 shows fifo_empty live, in the same cycle as the input. A write to these two bits has no effect.
- R3: A one on err_evt[k] sets sticky status bit k+2. The bit is visible on a read after the next rising clock edge. The mapping of err_evt is: bit 0 CRC, bit 1 single-bit ECC, bit 2 double-bit ECC, bit 3 undersize packet, bits 4-7 line sync for virtual channels 0-3, bits 8-11 frame sync for virtual channels 0-3, bit 12 initialization error.
- R4: A write to 0x00 clears each sticky bit whose wr_data bit is 1. Sticky bits whose wr_data bit is 0 keep their value.
- R5: When an event and a clearing write hit the same sticky bit in the same cycle, the bit ends up set.
- R6: The enable register is 15 bits and can be read and written at 0x04. It resets to 0.
- R7: irq is registered and equals the OR over bits i of (status[i] AND enable[i]). It follows a change in status or enable one clock edge later.
- R8: A data lane word returns lane_stat[8n+7:8n] with bits 4 and 7 forced to zero.
- R9: The clock lane word returns clk_lane_stat in bits 1:0, and all other bits are zero.
- R10: Writes to the lane words and to the clock lane word are ignored. Unmapped and unaligned addresses read as zero.
- R11: Reset clears all sticky bits, the enable register and irq.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| addr | input | 8 | Byte address of the register accessed |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 15 | Write data |
| rd_data | output | 32 | Read data for addr |
| fifo_full | input | 1 | Pixel FIFO full level |
| fifo_empty | input | 1 | Pixel FIFO empty level |
| err_evt | input | 13 | Error event pulses, mapping in R3 |
| lane_stat | input | 64 | Data lane PHY status, 8 bits per lane |
| clk_lane_stat | input | 2 | Clock lane PHY status |
| irq | output | 1 | Aggregated registered interrupt |

## Verification
The hardest case to reach is an error pulse that arrives in the same cycle as a clearing write to the same bit. The bench drives both on one falling edge, so they meet at a single rising edge, and then reads the bit back. The delay of irq is observed one sample after an enable write, before the new value has propagated, and again one edge later. The bench sweeps every sticky bit through set, write-zero, clear and isolated-enable. The sweep also covers every lane word and the whole unmapped address range.

// File: rtl/rx_irq_csr.sv
module rx_irq_csr #(
  parameter int LANES  = 8,
  parameter int ADDR_W = 8,
  parameter int DW     = 32
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [ADDR_W-1:0]  addr,
  input  logic               wr_en,
  input  logic [14:0]        wr_data,
  output logic [DW-1:0]      rd_data,
  input  logic               fifo_full,
  input  logic               fifo_empty,
  input  logic [12:0]        err_evt,
  input  logic [LANES*8-1:0] lane_stat,
  input  logic [1:0]         clk_lane_stat,
  output logic               irq
);
  localparam logic [ADDR_W-1:0] ST_OFS  = '0;
  localparam logic [ADDR_W-1:0] EN_OFS  = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] CLK_OFS = ADDR_W'(8 + 4 * LANES);
  localparam logic [7:0] LANE_MASK = 8'h6F;

  logic [12:0] sticky_q;
  logic [14:0] en_q;
  logic [14:0] status;
  logic        st_wr;
  logic [12:0] clr;

  assign st_wr  = wr_en && (addr == ST_OFS);
  assign clr    = st_wr ? wr_data[14:2] : '0;
  assign status = {sticky_q, fifo_empty, fifo_full};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      sticky_q <= '0;
      en_q     <= '0;
      irq      <= 1'b0;
    end else begin
      sticky_q <= (sticky_q & ~clr) | err_evt;
      if (wr_en && addr == EN_OFS) en_q <= wr_data;
      irq <= |(status & en_q);
    end

  always_comb begin
    rd_data = '0;
    if (addr == ST_OFS)       rd_data[14:0] = status;
    else if (addr == EN_OFS)  rd_data[14:0] = en_q;
    else if (addr == CLK_OFS) rd_data[1:0]  = clk_lane_stat;
    else
      for (int i = 0; i < LANES; i++)
        if (addr == ADDR_W'(8 + 4 * i)) rd_data[7:0] = lane_stat[i*8 +: 8] & LANE_MASK;
  end

  // R3
  evt_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_evt != 0) |=> ((sticky_q & $past(err_evt)) == $past(err_evt)));

  // R4
  w1c_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == ST_OFS && err_evt == 0) |=> ((sticky_q & $past(wr_data[14:2])) == 0));

  // R4
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && err_evt == 0) |=> $stable(sticky_q));

  // R7
  irq_masked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q == 0) |=> !irq);

  // R7
  irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((status & en_q) != 0) |=> irq);
endmodule

// File: tb/sim_rx_irq_csr.sv
module sim_rx_irq_csr;
  logic        clk = 0;
  logic        rst_n = 0;
  logic [7:0]  addr = 0;
  logic        wr_en = 0;
  logic [14:0] wr_data = 0;
  logic [31:0] rd_data;
  logic        fifo_full = 0, fifo_empty = 0;
  logic [12:0] err_evt = 0;
  logic [63:0] lane_stat = 0;
  logic [1:0]  clk_lane_stat = 0;
  logic        irq;

  int checks = 0, fails = 0;
  logic [12:0] m_st = 0;
  logic [14:0] m_en = 0;

  always #2 clk = ~clk;

  rx_irq_csr u0 (.clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .fifo_full(fifo_full), .fifo_empty(fifo_empty), .err_evt(err_evt),
    .lane_stat(lane_stat), .clk_lane_stat(clk_lane_stat), .irq(irq));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [7:0] a, input logic [31:0] exp, input string req);
    @(negedge clk); addr = a; #1; chk(req, rd_data, exp);
  endtask

  task automatic wr(input logic [7:0] a, input logic [14:0] d);
    @(negedge clk); addr = a; wr_data = d; wr_en = 1;
    if (a == 8'h00) m_st = m_st & ~d[14:2];
    if (a == 8'h04) m_en = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic pulse(input logic [12:0] e);
    @(negedge clk); err_evt = e; m_st = m_st | e;
    @(negedge clk); err_evt = 0;
  endtask

  function automatic logic [31:0] exp_st();
    return {17'b0, m_st, fifo_empty, fifo_full};
  endfunction

  task automatic irq_chk(input string req);
    @(negedge clk); @(negedge clk); #1;
    chk(req, {31'b0, irq}, {31'b0, |(exp_st() & {17'b0, m_en})});
  endtask

  initial begin
    #400000;
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [7:0] lv;
    #9 rst_n = 1;
    // R11 reset state
    rd(8'h00, 0, "R11");
    rd(8'h04, 0, "R6");
    #1 chk("R11", {31'b0, irq}, 0);

    // R2 live fifo bits, write ignored
    for (int f = 0; f < 4; f++) begin
      @(negedge clk); fifo_full = f[0]; fifo_empty = f[1];
      rd(8'h00, exp_st(), "R2");
    end
    fifo_full = 0; fifo_empty = 0;
    wr(8'h00, 15'h0003);
    rd(8'h00, exp_st(), "R2");

    // R6 enable readback
    for (int p = 0; p < 15; p++) begin
      wr(8'h04, 15'(1 << p) ^ 15'h2AAA);
      rd(8'h04, {17'b0, m_en}, "R6");
    end
    wr(8'h04, 0);

    // R3 R4 R7 per sticky bit
    for (int k = 0; k < 13; k++) begin
      pulse(13'(1 << k));
      rd(8'h00, exp_st(), "R3");
      wr(8'h00, ~15'(1 << (k + 2)) & 15'h7FFC);
      rd(8'h00, exp_st(), "R4");
      irq_chk("R7");
      @(negedge clk); addr = 8'h04; wr_data = 15'(1 << (k + 2)); wr_en = 1; m_en = wr_data;
      @(negedge clk); wr_en = 0; #1;
      chk("R7", {31'b0, irq}, 0);
      @(negedge clk); #1;
      chk("R7", {31'b0, irq}, 1);
      wr(8'h00, 15'(1 << (k + 2)));
      rd(8'h00, exp_st(), "R4");
      irq_chk("R7");
    end

    // R7 fifo bits through enable
    wr(8'h04, 15'h0002);
    @(negedge clk); fifo_empty = 1;
    irq_chk("R7");
    @(negedge clk); fifo_empty = 0;
    irq_chk("R7");
    wr(8'h04, 0);

    // R5 set wins
    pulse(13'h0010);
    @(negedge clk); addr = 8'h00; wr_data = 15'h7FFC; wr_en = 1; err_evt = 13'h0011;
    @(negedge clk); wr_en = 0; err_evt = 0;
    m_st = 13'h0011;
    rd(8'h00, exp_st(), "R5");

    // R11 reset clears sticky and enable
    wr(8'h04, 15'h7FFF);
    @(negedge clk); rst_n = 0; m_st = 0; m_en = 0;
    #1 chk("R11", {31'b0, irq}, 0);
    @(negedge clk); rst_n = 1;
    rd(8'h00, 0, "R11");
    rd(8'h04, 0, "R11");

    // R1 R8 lane words
    for (int v = 0; v < 4; v++) begin
      for (int n = 0; n < 8; n++) lane_stat[n*8 +: 8] = 8'((n * 37 + v * 91) ^ 8'hFF);
      for (int n = 0; n < 8; n++) begin
        lv = 8'((n * 37 + v * 91) ^ 8'hFF);
        rd(8'(8 + 4 * n), {24'b0, lv & 8'h6F}, "R8");
      end
    end
    // R10 lane write ignored
    wr(8'h08, 15'h7FFF);
    rd(8'h08, {24'b0, lane_stat[7:0] & 8'h6F}, "R10");

    // R9 clock lane
    for (int c = 0; c < 4; c++) begin
      @(negedge clk); clk_lane_stat = 2'(c);
      rd(8'h28, 32'(c), "R9");
    end
    wr(8'h28, 15'h7FFF);
    rd(8'h28, {30'b0, clk_lane_stat}, "R10");

    // R1 R10 unmapped and unaligned
    for (int a = 8'h2C; a < 256; a += 4) rd(8'(a), 0, "R1");
    for (int a = 1; a < 44; a++) if (a % 4 != 0) rd(8'(a), 0, "R10");
    rd(8'h00, exp_st(), "R1");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule